// File: doc/BRIEF.md
# Converter Host Bus Interface

This block is the processor-facing control logic of a successive-approximation converter. It takes the chip enable, the active-low chip select, the read/convert line, the word/byte format select and the byte address bit, and turns them into two things. The first is a conversion start for the sequencer, together with a latched length flag. The second is a 12-bit result bus that is driven nibble by nibble, with one output enable per nibble. The result can be read as one 12-bit word, or as two left-justified bytes on an 8-bit bus.

The sequencer supplies a busy flag and the 12-bit result. All control inputs are sampled on the block clock through one register stage, and every output is registered. An input change therefore shows at the outputs after two rising edges. A start is recognised on the rising edge of the combined start condition, so any one of the three qualifying inputs can be the last to complete it. On an 8-bit bus the low nibble lines are strapped to the high nibble lines. The enables never drive both of those nibbles at once.

Top module: `adc_host_if`

## Requirements
- R1: `start_o` pulses high for exactly one cycle when (enable high, select low, read/convert low) becomes true. Any of the three inputs may complete the condition last, and all three may change in the same cycle.
- R2: At each rising edge of the start condition, the address bit is captured into `short_cnv_o`. A value of 1 requests an 8-bit conversion and 0 requests a 12-bit one. The flag holds between starts.
- R3: A start condition that rises while busy is high produces no `start_o` pulse. It still captures the address bit into `short_cnv_o`.
- R4: All nibble enables are low unless read/convert is high, busy is low, enable is high and select is low.
- R5: With the format select high (word mode), a read enables all three nibbles (`nib_oe_o` = 3'b111) and drives the full result. The address bit has no effect.
- R6: In byte mode with the address bit low, a read enables nibbles 2 and 1 (`nib_oe_o` = 3'b110), which carry result bits 11..4. Nibble 2 is bits 11..8, nibble 1 is bits 7..4 and nibble 0 is bits 3..0.
- R7: In byte mode with the address bit high, a read enables nibbles 1 and 0 (3'b011). Nibble 1 is driven with zeros and nibble 0 carries result bits 3..0.
- R8: In byte mode, nibbles 2 and 0 are never enabled in the same cycle. When a read switches from one byte to the other, there is one cycle in which only nibble 1 is enabled before the new strapped nibble is enabled.
- R9: After reset, `start_o`, `short_cnv_o` and `nib_oe_o` are zero. Outputs respond to an input change at the second rising clock edge after it.
- R10: Data bits of a disabled nibble are driven zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chip_en_i | input | 1 | Chip enable, active high |
| chip_sel_ni | input | 1 | Chip select, active low |
| rd_cnv_ni | input | 1 | High selects read, low selects convert |
| fmt_word_i | input | 1 | 1: 12-bit word reads, 0: two byte reads |
| addr_lo_i | input | 1 | Byte address bit; also the length request at a start |
| busy_i | input | 1 | Sequencer conversion in progress |
| result_i | input | 12 | Conversion result from the sequencer |
| start_o | output | 1 | One-cycle conversion start pulse |
| short_cnv_o | output | 1 | Latched length flag, 1 = 8-bit conversion |
| data_o | output | 12 | Result bus, zero in disabled nibbles |
| nib_oe_o | output | 3 | Per-nibble output enable, bit 2 = bits 11..8 |

## Verification
The assertions assume that the busy flag is quiet for the first cycles after reset. They also assume that the inputs are level signals sampled once per clock, so a pulse shorter than a cycle is not seen. The stimulus changes the control inputs only between clock edges and holds each setting for at least two cycles. It raises busy only while no start condition is building, apart from the deliberate case that checks a start is suppressed while busy is high. The result value is changed only while busy is high or no read is open. As a result, the data seen on the bus always corresponds to one known value.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;
  localparam int NIB_W   = 4;
  localparam int NIB_N   = 3;
  localparam int DATA_W  = NIB_W * NIB_N;
  localparam int NIB_LO  = 0;
  localparam int NIB_MID = 1;
  localparam int NIB_HI  = NIB_N - 1;
  typedef logic [NIB_N-1:0] nib_mask_t;
endpackage

// File: rtl/adc_ctl_sync.sv
module adc_ctl_sync
  import adc_host_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_i,
  input  logic              cs_ni,
  input  logic              rc_ni,
  input  logic              fmt_i,
  input  logic              a0_i,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] res_i,
  output logic              ce_o,
  output logic              cs_no,
  output logic              rc_no,
  output logic              fmt_o,
  output logic              a0_o,
  output logic              busy_o,
  output logic [DATA_W-1:0] res_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_o   <= 1'b0;
      cs_no  <= 1'b1;
      rc_no  <= 1'b1;
      fmt_o  <= 1'b0;
      a0_o   <= 1'b0;
      busy_o <= 1'b0;
      res_o  <= '0;
    end else begin
      ce_o   <= ce_i;
      cs_no  <= cs_ni;
      rc_no  <= rc_ni;
      fmt_o  <= fmt_i;
      a0_o   <= a0_i;
      busy_o <= busy_i;
      res_o  <= res_i;
    end
  end
endmodule

// File: rtl/adc_start_gen.sv
module adc_start_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_i,
  input  logic cs_ni,
  input  logic rc_ni,
  input  logic a0_i,
  input  logic busy_i,
  output logic start_o,
  output logic short_o
);
  logic cond, cond_q, cond_rise;

  assign cond      = ce_i & ~cs_ni & ~rc_ni;
  assign cond_rise = cond & ~cond_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cond_q  <= 1'b0;
      start_o <= 1'b0;
      short_o <= 1'b0;
    end else begin
      cond_q  <= cond;
      start_o <= cond_rise & ~busy_i;
      // length is captured even when the start itself is refused
      if (cond_rise) short_o <= a0_i;
    end
  end

  assert_single_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  assert_len_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(cond_rise) |-> $stable(short_o));
endmodule

// File: rtl/adc_read_mux.sv
module adc_read_mux
  import adc_host_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_i,
  input  logic              cs_ni,
  input  logic              rc_ni,
  input  logic              fmt_i,
  input  logic              a0_i,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] res_i,
  output nib_mask_t         oe_o,
  output logic [DATA_W-1:0] data_o
);
  logic              rd_ok;
  nib_mask_t         req, oe_nxt;
  logic [DATA_W-1:0] data_nxt;

  assign rd_ok = ce_i & ~cs_ni & rc_ni & ~busy_i;

  always_comb begin
    req = '0;
    if (rd_ok) begin
      if (fmt_i)      req = '1;
      else if (!a0_i) req = nib_mask_t'((1 << NIB_HI) | (1 << NIB_MID));
      else            req = nib_mask_t'((1 << NIB_MID) | (1 << NIB_LO));
    end
    oe_nxt = req;
    // break-before-make on the strapped nibbles in byte mode
    if (!fmt_i) begin
      if (oe_o[NIB_LO]) oe_nxt[NIB_HI] = 1'b0;
      if (oe_o[NIB_HI]) oe_nxt[NIB_LO] = 1'b0;
    end
  end

  for (genvar i = 0; i < NIB_N; i++) begin : g_nib
    if (i == NIB_MID) begin : g_mid
      assign data_nxt[i*NIB_W +: NIB_W] =
        (oe_nxt[i] && (fmt_i || !a0_i)) ? res_i[i*NIB_W +: NIB_W] : '0;
    end else begin : g_pass
      assign data_nxt[i*NIB_W +: NIB_W] =
        oe_nxt[i] ? res_i[i*NIB_W +: NIB_W] : '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_o   <= '0;
      data_o <= '0;
    end else begin
      oe_o   <= oe_nxt;
      data_o <= data_nxt;
    end
  end

  assert_lo_byte_mid_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_o[NIB_LO] && !oe_o[NIB_HI]) |-> (data_o[NIB_MID*NIB_W +: NIB_W] == '0));
endmodule

// File: rtl/adc_host_if.sv
module adc_host_if
  import adc_host_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              chip_en_i,
  input  logic              chip_sel_ni,
  input  logic              rd_cnv_ni,
  input  logic              fmt_word_i,
  input  logic              addr_lo_i,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] result_i,
  output logic              start_o,
  output logic              short_cnv_o,
  output logic [DATA_W-1:0] data_o,
  output logic [NIB_N-1:0]  nib_oe_o
);
  logic              ce_q, cs_nq, rc_nq, fmt_q, a0_q, busy_q;
  logic [DATA_W-1:0] res_q;

  adc_ctl_sync u_sync (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .ce_i (chip_en_i), .cs_ni (chip_sel_ni), .rc_ni (rd_cnv_ni),
    .fmt_i (fmt_word_i), .a0_i (addr_lo_i), .busy_i (busy_i), .res_i (result_i),
    .ce_o (ce_q), .cs_no (cs_nq), .rc_no (rc_nq),
    .fmt_o (fmt_q), .a0_o (a0_q), .busy_o (busy_q), .res_o (res_q)
  );

  adc_start_gen u_start (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .ce_i (ce_q), .cs_ni (cs_nq), .rc_ni (rc_nq),
    .a0_i (a0_q), .busy_i (busy_q),
    .start_o (start_o), .short_o (short_cnv_o)
  );

  adc_read_mux u_rd (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .ce_i (ce_q), .cs_ni (cs_nq), .rc_ni (rc_nq),
    .fmt_i (fmt_q), .a0_i (a0_q), .busy_i (busy_q), .res_i (res_q),
    .oe_o (nib_oe_o), .data_o (data_o)
  );

  assert_no_start_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> !$past(busy_i, 2));
  assert_oe_needs_read_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|nib_oe_o) |-> $past(chip_en_i && !chip_sel_ni && rd_cnv_ni && !busy_i, 2));
  assert_strap_bbm_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nib_oe_o[NIB_HI] && nib_oe_o[NIB_LO]) |-> $past(fmt_word_i, 2));
  assert_off_nib_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nib_oe_o[NIB_HI] |-> (data_o[DATA_W-1 -: NIB_W] == '0));
endmodule

// File: tb/adc_host_if_bench.sv
module adc_host_if_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce = 1'b0, cs_n = 1'b1, rc_n = 1'b1, fmt = 1'b1, a0 = 1'b0, busy = 1'b0;
  logic [11:0] res = 12'hA5C;
  logic        start, short_f;
  logic [11:0] data;
  logic [2:0]  oe;

  int checks = 0, errors = 0, starts_seen = 0;
  bit done = 0;

  always #10 clk = ~clk;

  adc_host_if u_adc_host_if (
    .clk_i (clk), .rst_ni (rst_n), .chip_en_i (ce), .chip_sel_ni (cs_n),
    .rd_cnv_ni (rc_n), .fmt_word_i (fmt), .addr_lo_i (a0), .busy_i (busy),
    .result_i (res), .start_o (start), .short_cnv_o (short_f),
    .data_o (data), .nib_oe_o (oe)
  );

  // behavioural reference: one sampled-input stage, then registered outputs
  logic        s_ce, s_cs, s_rc, s_fmt, s_a0, s_busy, m_cond;
  logic [11:0] s_res;
  logic        e_start, e_short;
  logic [2:0]  e_oe;
  logic [11:0] e_data;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_ce = 0; s_cs = 1; s_rc = 1; s_fmt = 0; s_a0 = 0; s_busy = 0; s_res = 0;
      m_cond = 0; e_start = 0; e_short = 0; e_oe = 0; e_data = 0;
    end else begin
      logic c, rd;
      logic [2:0] r;
      c = s_ce && !s_cs && !s_rc;
      e_start = c && !m_cond && !s_busy;
      if (c && !m_cond) e_short = s_a0;
      m_cond = c;
      rd = s_ce && !s_cs && s_rc && !s_busy;
      if (!rd) r = 3'b000;
      else if (s_fmt) r = 3'b111;
      else if (!s_a0) r = 3'b110;
      else r = 3'b011;
      if (!s_fmt) begin
        if (e_oe[0]) r[2] = 0;
        if (e_oe[2]) r[0] = 0;
      end
      e_oe = r;
      e_data[11:8] = r[2] ? s_res[11:8] : 4'h0;
      e_data[7:4]  = (r[1] && (s_fmt || !s_a0)) ? s_res[7:4] : 4'h0;
      e_data[3:0]  = r[0] ? s_res[3:0] : 4'h0;
      s_ce = ce; s_cs = cs_n; s_rc = rc_n; s_fmt = fmt; s_a0 = a0; s_busy = busy; s_res = res;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R1 start", start, e_start);
    chk("R2 length", short_f, e_short);
    chk("R4-oe nib_oe R5 R6 R7 R8", oe, e_oe);
    chk("R10 data", data, e_data);
    if (start) starts_seen++;
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1; errors++;
      $display("FAIL R9 watchdog actual=timeout expected=finish");
      summary(); $finish;
    end
  end

  initial begin
    step(3); rst_n = 1; step(1);
    chk("R9 reset start", start, 0);
    chk("R9 reset oe", oe, 0);
    chk("R9 reset short", short_f, 0);

    // stand-alone word read
    ce = 1; cs_n = 0; rc_n = 1; fmt = 1; a0 = 0;
    step(1); chk("R9 latency oe", oe, 0);
    step(1); chk("R5 word oe", oe, 3'b111); chk("R5 word data", data, 12'hA5C);
    a0 = 1; step(2); chk("R5 a0 ignored", oe, 3'b111);
    // convert with a0 high
    rc_n = 0; step(2); chk("R1 start rc last", start, 1); chk("R2 short 8-bit", short_f, 1);
    step(1); chk("R1 single cycle", start, 0);
    busy = 1; rc_n = 1; step(3); chk("R4 busy hides data", oe, 0);
    res = 12'h3E7; step(1); busy = 0; step(3);
    chk("R5 new result", data, 12'h3E7);

    // ce completes last, a0 low
    ce = 0; rc_n = 0; a0 = 0; step(3);
    ce = 1; step(2); chk("R1 start ce last", start, 1); chk("R2 short 12-bit", short_f, 0);
    rc_n = 1; step(2);
    // cs completes last
    cs_n = 1; rc_n = 0; step(3);
    cs_n = 0; step(2); chk("R1 start cs last", start, 1);
    // all three together
    ce = 0; cs_n = 1; rc_n = 1; step(3);
    ce = 1; cs_n = 0; rc_n = 0; step(2); chk("R1 start simultaneous", start, 1);
    rc_n = 1; step(2);

    // start while busy: refused, a0 still captured
    busy = 1; step(2); a0 = 1; rc_n = 0; step(2);
    chk("R3 no start busy", start, 0); chk("R3 a0 captured", short_f, 1);
    step(2); rc_n = 1; step(2); busy = 0; step(3);

    // byte reads
    fmt = 0; a0 = 0; res = 12'h9B4; step(4);
    chk("R6 hi byte oe", oe, 3'b110); chk("R6 hi byte data", data, 12'h9B0);
    a0 = 1; step(2); chk("R8 dead cycle", oe, 3'b010);
    step(1); chk("R7 lo byte oe", oe, 3'b011); chk("R7 lo byte data", data, 12'h004);
    a0 = 0; step(2); chk("R8 dead cycle back", oe, 3'b010);
    step(1); chk("R6 hi byte again", oe, 3'b110);
    ce = 0; step(2); chk("R4 ce low", oe, 0); chk("R10 zero data", data, 0);
    step(2);

    chk("R1 start total", starts_seen, 4);
    done = 1;
    summary();
    $finish;
  end
endmodule